// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. It holds the accumulator and a five-bit condition register. Each cycle with the enable strobe high, it combines the accumulator with an 8-bit operand under a 4-bit operation code. The operand may come from a register, from memory or from an immediate. On the clock edge it writes the new accumulator value and the new condition bits.

Each operation has its own rule for the condition bits. Bitwise operations force the carry low, and they set or clear the half-carry depending on the operation. The rotates touch only the carry. Compare produces the flags of a subtraction but leaves the accumulator as it was. Decimal adjust corrects a binary sum of two packed BCD bytes, steered by the half-carry and carry left by that addition. A decoder outside the block supplies the operation code and the operand.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, acc_o is 0x00 and flags_o is 0b00000. The flags_o bit order is {sign[4], zero[3], half-carry[2], parity[1], carry[0]}.
- R2: Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 increment, 5 decrement, 6 AND, 7 OR, 8 XOR, 9 compare, 10 rotate left circular, 11 rotate right circular, 12 rotate left through carry, 13 rotate right through carry, 14 decimal adjust, 15 no operation. With en_i low, or with code 15, acc_o and flags_o keep their values.
- R3: Add (code 0) and add with carry (code 1) write A+B (+carry) to the accumulator. Carry is the carry out of bit 7 and half-carry is the carry out of bit 3.
- R4: Subtract (code 2) and subtract with borrow (code 3) write A-B (-carry) to the accumulator. Carry is set on a borrow out of bit 7 and half-carry on a borrow out of bit 3.
- R5: For every operation except the four rotates and no operation, sign is bit 7 of the result, zero is set when the result is 0x00, and parity is set when the result holds an even number of ones.
- R6: Increment (code 4) and decrement (code 5) act on the accumulator and leave carry unchanged. Half-carry is the carry or borrow across bit 3.
- R7: AND (code 6) clears carry and sets half-carry.
- R8: OR (code 7) and XOR (code 8) clear both carry and half-carry.
- R9: Compare (code 9) leaves the accumulator unchanged. It sets the flags as A-B would: carry set when A<B (unsigned), zero set when A equals B, and both clear when A>B.
- R10: Rotate left circular moves bit 7 to bit 0 and into carry. Rotate right circular moves bit 0 to bit 7 and into carry. Sign, zero, half-carry and parity are unchanged.
- R11: Rotate left through carry sends bit 7 to carry and the old carry to bit 0. Rotate right through carry sends bit 0 to carry and the old carry to bit 7. Only carry among the flags changes.
- R12: Decimal adjust adds 0x06 when the low nibble exceeds 9 or half-carry is set. Half-carry becomes the carry out of that low-nibble addition. It then adds 0x60 when the resulting high nibble exceeds 9, when carry is set, or when the first step carried out of bit 7. Carry is set when either step carries out of bit 7 and is never cleared if it was set on entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Update strobe; state changes only when high |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Second operand |
| acc_o | output | 8 | Registered accumulator |
| flags_o | output | 5 | Registered flags {sign, zero, half-carry, parity, carry} |

## Verification
The bench targets half-carry across bit 3 in both directions. A design that tapped the wrong bit, or that did not invert the carry for subtraction, would report a half-carry where a borrow should show, and the reverse. It covers compare at less, equal and greater, so a design that wrote the difference back or swapped the borrow sense would be exposed. The bench runs the through-carry rotates with carry both set and clear, to catch a design that reused the circular path. It also covers decimal adjust on sums that need the low correction, the high correction, both corrections, or the carry-in path, where a design that cleared an incoming carry or skipped the second correction would leave a wrong BCD byte.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int DW   = 8;
  localparam int NW   = 4;
  localparam int NIBS = DW / NW;
  localparam int FW   = 5;
  localparam int OPW  = 4;

  localparam int F_CY = 0;
  localparam int F_P  = 1;
  localparam int F_AC = 2;
  localparam int F_Z  = 3;
  localparam int F_S  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
    OP_XOR = 4'd8,  OP_CMP = 4'd9,  OP_RLC = 4'd10, OP_RRC = 4'd11,
    OP_RAL = 4'd12, OP_RAR = 4'd13, OP_DAA = 4'd14, OP_NOP = 4'd15
  } op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
// Nibble-ripple adder; sub_i turns it into a - b - cin with borrow outputs.
module acc_alu_addsub #(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o,
  output logic          hc_o
);
  localparam int NIBS = DW / NW;

  logic [DW-1:0] b_eff;
  logic [NIBS:0] c;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign c[0]  = cin_i ^ sub_i;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign {c[g+1], sum_o[g*NW +: NW]} = {1'b0, a_i[g*NW +: NW]}
                                       + {1'b0, b_eff[g*NW +: NW]}
                                       + {{NW{1'b0}}, c[g]};
  end

  assign cy_o = c[NIBS] ^ sub_i;
  assign hc_o = c[1] ^ sub_i;
endmodule

// File: rtl/acc_alu_bitops.sv
`timescale 1ns/1ps
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  input  op_e           op_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    ac_o  = 1'b0;
    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; ac_o = 1'b1; end
      OP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; end
      OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
      OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_RAL: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_decadj.sv
`timescale 1ns/1ps
module acc_alu_decadj
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          ac_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          ac_o,
  output logic          cy_o
);
  localparam logic [NW-1:0] NINE    = NW'(9);
  localparam logic [DW:0]   LO_STEP = (DW+1)'(6);
  localparam logic [DW:0]   HI_STEP = (DW+1)'(6) << NW;

  logic          lo_fix, hi_fix;
  logic [NW:0]   lo_sum;
  logic [DW:0]   t, u;

  assign lo_fix = (a_i[NW-1:0] > NINE) | ac_i;
  assign lo_sum = {1'b0, a_i[NW-1:0]} + (lo_fix ? (NW+1)'(6) : '0);
  assign t      = {1'b0, a_i} + (lo_fix ? LO_STEP : '0);
  // t[DW] only when a_i = 0xFA..0xFF with low fix
  assign hi_fix = (t[DW-1 -: NW] > NINE) | cy_i | t[DW];
  assign u      = {1'b0, t[DW-1:0]} + (hi_fix ? HI_STEP : '0);

  assign res_o = u[DW-1:0];
  assign ac_o  = lo_sum[NW];
  assign cy_o  = cy_i | t[DW] | u[DW];
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  opnd_i,
  output logic [DW-1:0]  acc_o,
  output logic [FW-1:0]  flags_o
);
  op_e           op;
  logic [DW-1:0] acc_q, acc_d;
  logic [FW-1:0] fl_q, fl_d;

  logic [DW-1:0] as_b, as_sum;
  logic          as_cin, as_sub, as_cy, as_hc;
  logic [DW-1:0] bo_res, da_res, res;
  logic          bo_cy, bo_ac, da_ac, da_cy;

  assign op = op_e'(op_i);

  always_comb begin
    as_b   = opnd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_ADC: as_cin = fl_q[F_CY];
      OP_SUB,
      OP_CMP: as_sub = 1'b1;
      OP_SBB: begin as_sub = 1'b1; as_cin = fl_q[F_CY]; end
      OP_INC: begin as_b = '0; as_cin = 1'b1; end
      OP_DEC: begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
      default: ;
    endcase
  end

  acc_alu_addsub #(.DW(DW), .NW(NW)) u_addsub (
    .a_i   (acc_q),
    .b_i   (as_b),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .sum_o (as_sum),
    .cy_o  (as_cy),
    .hc_o  (as_hc)
  );

  acc_alu_bitops u_bitops (
    .a_i   (acc_q),
    .b_i   (opnd_i),
    .cy_i  (fl_q[F_CY]),
    .op_i  (op),
    .res_o (bo_res),
    .cy_o  (bo_cy),
    .ac_o  (bo_ac)
  );

  acc_alu_decadj u_decadj (
    .a_i   (acc_q),
    .ac_i  (fl_q[F_AC]),
    .cy_i  (fl_q[F_CY]),
    .res_o (da_res),
    .ac_o  (da_ac),
    .cy_o  (da_cy)
  );

  always_comb begin
    acc_d = acc_q;
    fl_d  = fl_q;
    res   = as_sum;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        res          = as_sum;
        fl_d[F_AC]   = as_hc;
        fl_d[F_CY]   = as_cy;
      end
      OP_INC, OP_DEC: begin
        res          = as_sum;
        fl_d[F_AC]   = as_hc;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res          = bo_res;
        fl_d[F_AC]   = bo_ac;
        fl_d[F_CY]   = bo_cy;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res          = bo_res;
        fl_d[F_CY]   = bo_cy;
      end
      OP_DAA: begin
        res          = da_res;
        fl_d[F_AC]   = da_ac;
        fl_d[F_CY]   = da_cy;
      end
      default: res = acc_q;
    endcase

    // result-bearing ops refresh sign/zero/parity
    if (!(op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_NOP})) begin
      fl_d[F_S] = res[DW-1];
      fl_d[F_Z] = (res == '0);
      fl_d[F_P] = ~^res;
    end
    if (op != OP_CMP && op != OP_NOP) acc_d = res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      fl_q  <= '0;
    end else if (en_i) begin
      acc_q <= acc_d;
      fl_q  <= fl_d;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = fl_q;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  opnd_i,
  input logic [DW-1:0]  acc_o,
  input logic [FW-1:0]  flags_o
);
  op_e op;
  assign op = op_e'(op_i);

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == '0 && flags_o == '0));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || op == OP_NOP) |=> (acc_o == $past(acc_o) && flags_o == $past(flags_o)));

  p_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_ADD) |=>
      ({flags_o[F_CY], acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(opnd_i)})));

  p_sub_borrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_SUB) |=> (flags_o[F_CY] == ($past(acc_o) < $past(opnd_i))));

  p_szp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_NOP, OP_CMP})) |=>
      (flags_o[F_Z] == (acc_o == '0) && flags_o[F_P] == ~^acc_o && flags_o[F_S] == acc_o[DW-1]));

  p_incdec_cy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op == OP_INC || op == OP_DEC)) |=> (flags_o[F_CY] == $past(flags_o[F_CY])));

  p_and_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_AND) |=> (!flags_o[F_CY] && flags_o[F_AC]));

  p_orx_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op == OP_OR || op == OP_XOR)) |=> (!flags_o[F_CY] && !flags_o[F_AC]));

  p_cmp_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_CMP) |=> (acc_o == $past(acc_o)));

  p_cmp_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_CMP) |=>
      (flags_o[F_CY] == ($past(acc_o) < $past(opnd_i)) &&
       flags_o[F_Z] == ($past(acc_o) == $past(opnd_i))));

  p_rot_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR}) |=>
      (flags_o[FW-1:1] == $past(flags_o[FW-1:1])));

  p_rlc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_RLC) |=>
      (acc_o == {$past(acc_o[DW-2:0]), $past(acc_o[DW-1])} && flags_o[F_CY] == $past(acc_o[DW-1])));

  p_ral_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_RAL) |=>
      (acc_o == {$past(acc_o[DW-2:0]), $past(flags_o[F_CY])} && flags_o[F_CY] == $past(acc_o[DW-1])));

  p_daa_cy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_DAA && flags_o[F_CY]) |=> flags_o[F_CY]);
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .op_i    (op_i),
  .opnd_i  (opnd_i),
  .acc_o   (acc_o),
  .flags_o (flags_o)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] op_i = 4'd15;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] acc_o;
  logic [4:0] flags_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_acc = 8'h00;
  logic [4:0] m_fl  = 5'b0;   // {S,Z,AC,P,CY}

  logic [12:0] exp_q[$];
  string       tag_q[$];

  acc_alu u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
    .opnd_i(opnd_i), .acc_o(acc_o), .flags_o(flags_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic string tag_of(input int op);
    case (op)
      0, 1:         return "R3";
      2, 3:         return "R4";
      4, 5:         return "R6";
      6:            return "R7";
      7, 8:         return "R8";
      9:            return "R9";
      10, 11:       return "R10";
      12, 13:       return "R11";
      14:           return "R12";
      default:      return "R2";
    endcase
  endfunction

  task automatic model_step(input int op, input int b);
    int a, c, r, t, lo, hi, add6, cx;
    logic [7:0] r8;
    logic s, z, p, ac, cy;
    bit szp, wr;
    a = m_acc; c = m_fl[0]; r = a;
    {s, z, ac, p, cy} = m_fl;
    szp = 1; wr = 1;
    case (op)
      0: begin r = a + b;     ac = ((a % 16) + (b % 16)) > 15;     cy = r > 255; end
      1: begin r = a + b + c; ac = ((a % 16) + (b % 16) + c) > 15; cy = r > 255; end
      2: begin r = a - b;     ac = (a % 16) < (b % 16);     cy = a < b; end
      3: begin r = a - b - c; ac = (a % 16) < (b % 16) + c; cy = a < b + c; end
      4: begin r = a + 1; ac = (a % 16) == 15; end
      5: begin r = a - 1; ac = (a % 16) == 0; end
      6: begin r = a & b; ac = 1; cy = 0; end
      7: begin r = a | b; ac = 0; cy = 0; end
      8: begin r = a ^ b; ac = 0; cy = 0; end
      9: begin r = a - b; ac = (a % 16) < (b % 16); cy = a < b; wr = 0; end
      10: begin r = ((a * 2) % 256) + (a / 128); cy = (a / 128) != 0; szp = 0; end
      11: begin r = (a / 2) + (a % 2) * 128;     cy = (a % 2) != 0;   szp = 0; end
      12: begin r = ((a * 2) % 256) + c;         cy = (a / 128) != 0; szp = 0; end
      13: begin r = (a / 2) + c * 128;           cy = (a % 2) != 0;   szp = 0; end
      14: begin
        lo = a % 16;
        add6 = (lo > 9 || ac) ? 6 : 0;
        ac = (lo + add6) > 15;
        t = a + add6;
        cx = (t > 255) ? 1 : 0;
        t = t % 256;
        hi = t / 16;
        if (hi > 9 || c != 0 || cx != 0) t = t + 96;
        cy = (c != 0) || (cx != 0) || (t > 255);
        r = t % 256;
      end
      default: return;
    endcase
    r8 = 8'(r);
    if (szp) begin
      s = r8[7];
      z = (r8 == 8'h00);
      p = ~^r8;
    end
    if (wr) m_acc = r8;
    m_fl = {s, z, ac, p, cy};
  endtask

  // driver: one cycle per call, expected value pushed for the monitor
  task automatic drive(input int op, input int b, input bit en, input string tag);
    @(negedge clk_i);
    op_i   = 4'(op);
    opnd_i = 8'(b);
    en_i   = en;
    if (en) model_step(op, b);
    exp_q.push_back({m_acc, m_fl});
    tag_q.push_back(tag);
  endtask

  task automatic op_do(input int op, input int b);
    drive(op, b, 1'b1, tag_of(op));
  endtask

  task automatic load(input int v);
    op_do(6, 0);
    op_do(7, v);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        logic [12:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if ({acc_o, flags_o} !== e) begin
          failures++;
          $display("FAIL %s acc=%02h flags=%05b expected acc=%02h flags=%05b",
                   tg, acc_o, flags_o, e[12:5], e[4:0]);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    checks++;
    if (acc_o !== 8'h00 || flags_o !== 5'b0) begin
      failures++;
      $display("FAIL R1 acc=%02h flags=%05b expected acc=00 flags=00000", acc_o, flags_o);
    end
    rst_ni = 1'b1;

    // R8 / R5: OR load, XOR to zero
    op_do(7, 8'h35);
    op_do(8, 8'h35);
    // R3: half-carry, carry out, add with carry
    op_do(0, 8'h0F);
    op_do(0, 8'h01);
    op_do(0, 8'hF0);
    op_do(1, 8'h00);
    // R4: borrow out, subtract with borrow
    op_do(2, 8'h02);
    op_do(3, 8'h0F);
    op_do(2, 8'h01);
    // R6: inc/dec with carry both ways
    load(8'h0F); op_do(4, 0); op_do(5, 0);
    load(8'h00); op_do(5, 0); op_do(4, 0);
    op_do(2, 8'h01); op_do(4, 0);
    // R7
    load(8'hA5); op_do(6, 8'h3C);
    // R9: less, equal, greater
    load(8'h40); op_do(9, 8'h41); op_do(9, 8'h40); op_do(9, 8'h3F);
    // R10 / R11
    load(8'h81); op_do(10, 0); op_do(10, 0); op_do(11, 0); op_do(11, 0);
    load(8'h80); op_do(12, 0); op_do(12, 0); op_do(13, 0); op_do(13, 0);
    // R12: low fix, both fixes, carry-in path, upper overflow
    load(8'h15); op_do(0, 8'h27); op_do(14, 0);
    load(8'h99); op_do(0, 8'h01); op_do(14, 0);
    load(8'h80); op_do(0, 8'h80); op_do(14, 0);
    load(8'h09); op_do(0, 8'h09); op_do(14, 0);
    load(8'hFA); op_do(14, 0);
    // R2: strobe low and no-operation code
    load(8'h5A);
    drive(0, 8'h11, 1'b0, "R2");
    drive(8, 8'hFF, 1'b0, "R2");
    drive(15, 8'hFF, 1'b1, "R2");

    // mixed sweep across all codes and operand values
    for (int i = 0; i < 400; i++) begin
      int op;
      bit en;
      op = (i * 7 + 3) % 16;
      en = (i % 9) != 0;
      drive(op, (i * 73 + 11) % 256, en, en ? tag_of(op) : "R2");
    end

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule